// File: doc/BRIEF.md
# Instruction Memory with Side-Band Lock Bit

This block is the instruction-side memory subsystem for a cache that loads and locks lines as it fetches them. Next to the word-wide instruction store it keeps a small byte-wide lock table. Each bit of that table belongs to one memory block of `BLOCK_INSTRS` instructions, so one byte covers eight consecutive blocks. The table needs one byte for every eight blocks: 32 bytes at the default sizes of 1024 words and four instructions per block.

On every fetch both stores are read in the same cycle. The block picks the addressed block's bit out of the lock byte with one 8-to-1 selection and returns it on an extra response line, next to the instruction word. A fetch therefore costs no more than it would without the lock information.

Requests and responses are valid/ready streams with a single response register. A request is taken on a rising clock edge where `req_valid` and `req_ready` are both high. While a response is held and `rsp_ready` is low, `req_ready` stays low and the response does not change. A loader fills both stores before execution through plain write-enable ports.

Top module: `lsm_fetch_mem`

## Requirements
- R1: After reset `rsp_valid` is low and `req_ready` is high.
- R2: An accepted request raises `rsp_valid` on the next clock edge, with `rsp_data` equal to the instruction word at index `req_addr[11:2]`.
- R3: `rsp_lock` equals bit `req_addr[6:4]` of lock byte `req_addr[11:7]` (default sizes: 4-byte instructions, 4 instructions per block).
- R4: The lock bit and the instruction word of one request are delivered on the same response beat.
- R5: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_data` and `rsp_lock` hold their values.
- R6: `req_ready` is low exactly when a response is held and `rsp_ready` is low, so back-to-back requests are taken one per cycle while the consumer is ready.
- R7: A loader write to the word or lock byte that a request reads in the same cycle returns the old value to that request; later requests see the new value.
- R8: The two least significant address bits (byte within an instruction) have no effect on the response.
- R9: A lock-byte write changes the lock bits of its own eight blocks only; blocks covered by other bytes read back unchanged.
- R10: Responses come out in request order, exactly one per accepted request, and none appears without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Fetch request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_addr | input | 12 | Byte address of the fetch |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 32 | Instruction word |
| rsp_lock | output | 1 | Lock bit of the block holding the word |
| ld_instr_we | input | 1 | Loader write strobe, instruction store |
| ld_instr_idx | input | 10 | Loader word index |
| ld_instr_data | input | 32 | Loader word data |
| ld_lock_we | input | 1 | Loader write strobe, lock table |
| ld_lock_idx | input | 5 | Loader lock-byte index |
| ld_lock_data | input | 8 | Loader lock-byte data |

## Verification
The bench sweeps the eight bit positions inside lock bytes and reads blocks on both sides of a byte boundary. A design that took the bit index or the byte index from the wrong address bits returns lock bits that belong to a neighbouring block. Reads under a random ready pattern catch a design that lets its response change, or that accepts a new request, while a response is stalled; such a design would lose or overwrite fetches. A write and a read of the same word and lock byte in one cycle show whether a design forwards the new value when it should return the old one. Requests with the low address bits set show whether those bits leak into the word or block selection.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  // Number of block lock bits packed into one byte of the lock table.
  localparam int unsigned LOCKS_PER_BYTE = 8;
  localparam int unsigned LOCK_SEL_W     = 3;
  localparam int unsigned LOCK_BYTE_W    = 8;
endpackage

// File: rtl/lsm_addr_split.sv
module lsm_addr_split #(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned BYTE_OFS_W = 2,
  parameter int unsigned BLK_SHIFT  = 4,
  parameter int unsigned LOCK_SHIFT = 7
) (
  input  logic [ADDR_W-1:0]            addr_i,
  output logic [ADDR_W-BYTE_OFS_W-1:0] word_idx_o,
  output logic [ADDR_W-LOCK_SHIFT-1:0] lock_idx_o,
  output logic [LOCK_SHIFT-BLK_SHIFT-1:0] bit_sel_o
);
  // Byte offset inside an instruction does not take part in any selection.
  logic unused_byte_ofs;
  assign unused_byte_ofs = ^addr_i[BYTE_OFS_W-1:0];

  assign word_idx_o = addr_i[ADDR_W-1:BYTE_OFS_W];
  assign lock_idx_o = addr_i[ADDR_W-1:LOCK_SHIFT];
  assign bit_sel_o  = addr_i[LOCK_SHIFT-1:BLK_SHIFT];
endmodule

// File: rtl/lsm_sync_ram.sv
module lsm_sync_ram #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             re_i,
  input  logic [IDX_W-1:0] ridx_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] store [DEPTH];

  // Read-before-write: a same-cycle read sees the value from before the write.
  always_ff @(posedge clk) begin
    if (we_i) store[widx_i] <= wdata_i;
    if (re_i) rdata_o <= store[ridx_i];
  end
endmodule

// File: rtl/lsm_bit_pick.sv
module lsm_bit_pick
  import lsm_pkg::*;
(
  input  logic [LOCK_BYTE_W-1:0] byte_i,
  input  logic [LOCK_SEL_W-1:0]  sel_i,
  output logic                   bit_o
);
  logic [LOCKS_PER_BYTE-1:0] hit;

  // One-hot decode of the index, then OR of the gated bits: an 8-to-1 selection.
  for (genvar g = 0; g < LOCKS_PER_BYTE; g++) begin : g_leg
    assign hit[g] = (sel_i == LOCK_SEL_W'(g)) & byte_i[g];
  end

  assign bit_o = |hit;
endmodule

// File: rtl/lsm_fetch_mem.sv
module lsm_fetch_mem
  import lsm_pkg::*;
#(
  parameter int unsigned INSTR_BYTES  = 4,
  parameter int unsigned BLOCK_INSTRS = 4,
  parameter int unsigned MEM_WORDS    = 1024,
  localparam int unsigned INSTR_W     = 8 * INSTR_BYTES,
  localparam int unsigned WORD_IDX_W  = $clog2(MEM_WORDS),
  localparam int unsigned BYTE_OFS_W  = $clog2(INSTR_BYTES),
  localparam int unsigned ADDR_W      = WORD_IDX_W + BYTE_OFS_W,
  localparam int unsigned BLK_SHIFT   = $clog2(BLOCK_INSTRS * INSTR_BYTES),
  localparam int unsigned LOCK_SHIFT  = BLK_SHIFT + LOCK_SEL_W,
  localparam int unsigned LOCK_DEPTH  = MEM_WORDS / (BLOCK_INSTRS * LOCKS_PER_BYTE),
  localparam int unsigned LOCK_IDX_W  = $clog2(LOCK_DEPTH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [ADDR_W-1:0]      req_addr,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic [INSTR_W-1:0]     rsp_data,
  output logic                   rsp_lock,
  input  logic                   ld_instr_we,
  input  logic [WORD_IDX_W-1:0]  ld_instr_idx,
  input  logic [INSTR_W-1:0]     ld_instr_data,
  input  logic                   ld_lock_we,
  input  logic [LOCK_IDX_W-1:0]  ld_lock_idx,
  input  logic [LOCK_BYTE_W-1:0] ld_lock_data
);
  logic                   accept;
  logic [WORD_IDX_W-1:0]  word_idx;
  logic [LOCK_IDX_W-1:0]  lock_idx;
  logic [LOCK_SEL_W-1:0]  bit_sel;
  logic [LOCK_SEL_W-1:0]  bit_sel_q;
  logic [LOCK_BYTE_W-1:0] lock_byte_q;

  // Single response slot: take a request when the slot is empty or draining.
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  lsm_addr_split #(
    .ADDR_W    (ADDR_W),
    .BYTE_OFS_W(BYTE_OFS_W),
    .BLK_SHIFT (BLK_SHIFT),
    .LOCK_SHIFT(LOCK_SHIFT)
  ) u_split (
    .addr_i    (req_addr),
    .word_idx_o(word_idx),
    .lock_idx_o(lock_idx),
    .bit_sel_o (bit_sel)
  );

  // Both stores are read on the same edge, so the lock bit costs no extra cycle.
  lsm_sync_ram #(.WIDTH(INSTR_W), .DEPTH(MEM_WORDS)) u_instr_ram (
    .clk    (clk),
    .we_i   (ld_instr_we),
    .widx_i (ld_instr_idx),
    .wdata_i(ld_instr_data),
    .re_i   (accept),
    .ridx_i (word_idx),
    .rdata_o(rsp_data)
  );

  lsm_sync_ram #(.WIDTH(LOCK_BYTE_W), .DEPTH(LOCK_DEPTH)) u_lock_ram (
    .clk    (clk),
    .we_i   (ld_lock_we),
    .widx_i (ld_lock_idx),
    .wdata_i(ld_lock_data),
    .re_i   (accept),
    .ridx_i (lock_idx),
    .rdata_o(lock_byte_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      bit_sel_q <= '0;
    end else begin
      if (accept) begin
        rsp_valid <= 1'b1;
        bit_sel_q <= bit_sel;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  lsm_bit_pick u_pick (
    .byte_i(lock_byte_q),
    .sel_i (bit_sel_q),
    .bit_o (rsp_lock)
  );
endmodule

// File: rtl/lsm_fetch_mem_chk.sv
module lsm_fetch_mem_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic              rsp_lock
);
  p_hold_under_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_lock)))
    else $error("R5: response changed while stalled");

  p_no_take_when_stalled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready)
    else $error("R6: request accepted while response stalled");

  p_ready_when_draining_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready) |-> req_ready)
    else $error("R6: no request taken while slot drains");

  p_one_cycle_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid)
    else $error("R2: response missing one cycle after accept");

  p_no_phantom_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !$past(rsp_valid && !rsp_ready)) |-> $past(req_valid && req_ready))
    else $error("R10: response without a request");
endmodule

bind lsm_fetch_mem lsm_fetch_mem_chk #(.DATA_W(INSTR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready),
  .rsp_data (rsp_data),
  .rsp_lock (rsp_lock)
);

// File: tb/lsm_fetch_mem_test.sv
module lsm_fetch_mem_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [11:0] req_addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_data;
  logic        rsp_lock;
  logic        ld_instr_we = 1'b0;
  logic [9:0]  ld_instr_idx = '0;
  logic [31:0] ld_instr_data = '0;
  logic        ld_lock_we = 1'b0;
  logic [4:0]  ld_lock_idx = '0;
  logic [7:0]  ld_lock_data = '0;

  int checks = 0;
  int errors = 0;
  logic [31:0] m_instr [1024];
  logic [7:0]  m_lock  [32];
  logic [32:0] sb_q [$];
  int          bp_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic        done = 1'b0;

  always #10 clk = ~clk;

  lsm_fetch_mem uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .rsp_lock(rsp_lock),
    .ld_instr_we(ld_instr_we), .ld_instr_idx(ld_instr_idx), .ld_instr_data(ld_instr_data),
    .ld_lock_we(ld_lock_we), .ld_lock_idx(ld_lock_idx), .ld_lock_data(ld_lock_data)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Expected word (R2) and lock bit (R3, byte addr[11:7], bit addr[6:4]) from the model.
  function automatic logic [32:0] expect_of(input logic [11:0] a);
    logic [7:0] b;
    b = m_lock[a[11:7]];
    return {b[a[6:4]], m_instr[a[11:2]]};
  endfunction

  task automatic load_instr(input int idx, input logic [31:0] d);
    @(negedge clk);
    ld_instr_we = 1'b1; ld_instr_idx = 10'(idx); ld_instr_data = d;
    @(negedge clk);
    ld_instr_we = 1'b0;
    m_instr[idx] = d;
  endtask

  task automatic load_lock(input int idx, input logic [7:0] d);
    @(negedge clk);
    ld_lock_we = 1'b1; ld_lock_idx = 5'(idx); ld_lock_data = d;
    @(negedge clk);
    ld_lock_we = 1'b0;
    m_lock[idx] = d;
  endtask

  // Driver: present one request, push its expected result when it is taken.
  task automatic issue(input logic [11:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    while (!req_ready) @(negedge clk);
    sb_q.push_back(expect_of(a));
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  // Consumer ready pattern, changed just after the edge.
  always @(posedge clk) begin
    #2;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    rsp_ready = (bp_mode == 0) ? 1'b1 : lfsr[0];
  end

  // Monitor: stall stability (R5), ready rule (R6), in-order compare (R2, R3, R4, R10).
  logic        was_stalled = 1'b0;
  logic [32:0] held;
  always @(negedge clk) begin
    if (rst_n) begin
      if (was_stalled)
        check(rsp_valid && {rsp_lock, rsp_data} == held, "R5 hold", {rsp_data[30:0], rsp_lock}, {held[30:0], held[32]});
      check(req_ready == (!rsp_valid || rsp_ready), "R6 ready", 32'(req_ready), 32'(!rsp_valid || rsp_ready));
      was_stalled = rsp_valid && !rsp_ready;
      held = {rsp_lock, rsp_data};
      if (rsp_valid && rsp_ready) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R10 extra response", rsp_data, 32'h0);
        end else begin
          logic [32:0] e;
          e = sb_q.pop_front();
          check(rsp_data == e[31:0], "R2 data", rsp_data, e[31:0]);
          check(rsp_lock == e[32], "R3 lock", 32'(rsp_lock), 32'(e[32]));
        end
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R1: idle after reset
    check(!rsp_valid, "R1 rsp_valid", 32'(rsp_valid), 32'h0);
    check(req_ready, "R1 req_ready", 32'(req_ready), 32'h1);

    for (int i = 0; i < 1024; i++) load_instr(i, 32'hC3A50000 ^ (i * 32'h9E3779B1));
    for (int j = 0; j < 32; j++) load_lock(j, 8'(j * 37 + 11));

    // R2: one request, response on the next edge
    issue(12'h124);
    @(negedge clk);
    check(rsp_valid, "R2 latency", 32'(rsp_valid), 32'h1);
    repeat (2) @(negedge clk);

    // R3: every bit position in several lock bytes, including byte boundaries
    for (int j = 0; j < 32; j += 5)
      for (int k = 0; k < 8; k++) issue(12'((j << 7) | (k << 4) | 8));
    issue(12'h07F); issue(12'h080);

    // R8: low two address bits ignored
    for (int k = 0; k < 4; k++) issue(12'h5A0 | 12'(k));

    // R4 / R6 / R5 / R10: back-pressure with random ready
    bp_mode = 1;
    for (int i = 0; i < 200; i++) issue(12'((i * 52 + 13) % 4096));
    bp_mode = 0;
    repeat (6) @(negedge clk);

    // R9: rewrite one lock byte, neighbours stay
    load_lock(10, 8'hFF);
    for (int k = 0; k < 8; k++) begin
      issue(12'((10 << 7) | (k << 4)));
      issue(12'((9 << 7) | (k << 4)));
      issue(12'((11 << 7) | (k << 4)));
    end
    load_lock(10, 8'h00);
    for (int k = 0; k < 8; k++) issue(12'((10 << 7) | (k << 4)));
    repeat (4) @(negedge clk);

    // R7: same-cycle write and read return the old value
    @(negedge clk);
    req_valid = 1'b1; req_addr = 12'h3C4;
    ld_instr_we = 1'b1; ld_instr_idx = 10'h0F1; ld_instr_data = 32'h5EED_F00D;
    ld_lock_we = 1'b1; ld_lock_idx = 5'd7; ld_lock_data = ~m_lock[7];
    sb_q.push_back(expect_of(12'h3C4));
    @(posedge clk);
    #1 req_valid = 1'b0; ld_instr_we = 1'b0; ld_lock_we = 1'b0;
    m_instr[10'h0F1] = 32'h5EED_F00D;
    m_lock[7] = ld_lock_data;
    issue(12'h3C4);

    repeat (10) @(negedge clk);
    check(sb_q.size() == 0, "R10 all answered", 32'(sb_q.size()), 32'h0);
    done = 1'b1;
    finish_run();
  end
endmodule